// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block drives the six gate signals of a three-phase voltage-source inverter. A triangular up/down counter sets the switching period. Three duty values are compared against the counter to produce one complementary high/low pair per phase. The pulses are centred on the middle of the period. A dead gap separates each high-side edge from its low-side partner, and pulses shorter than a programmed minimum are suppressed.

Between the comparators and the pins, four stages act in turn. Per-pair crossover swaps the two signals of a pair. Per-pin enables mask single outputs. A square chopping carrier can be mixed into the high group, the low group or both, which suits pulse-transformer gate drives. An active-low trip input shuts every output off at once and keeps them off until reset, with a single interrupt pulse. A one-cycle sync pulse marks the start of each period. Duty values are reloaded once per period, or twice per period in double-update mode.

Top module: `cpwm_gen`

## Requirements
- R1: While reset is applied, and until the second rising clock edge after `rst_ni` rises, all six outputs, `sync_o` and `trip_irq_o` are low.
- R2: With H = max(`per_i`, 2) as captured at period start, the counter runs 0,1,…,H-1 counting up, then H-1,…,0 counting down, so a period lasts 2H cycles. `sync_o` is high for one cycle at the output of counter value 0 in the up phase, and outputs lag the counter by one register.
- R3: With dc = min(duty, H), a high-side signal is on where the counter is ≥ H - dc + dead. This gives 2·(dc - dead) cycles per period, centred on the midpoint, and nothing when dc ≤ dead.
- R4: A low-side signal is on where the counter is < H - dc, giving 2·(H - dc) cycles. The two signals of a pair are never on together.
- R5: If a high-side half-pulse (dc - dead) or a low-side half-pulse (H - dc) is shorter than `pmin_i`, that signal stays off for the whole period. A value of 0 disables this rule.
- R6: When crossover bit k of `xover_i` is set (bit 0 = phase A, bit 1 = B, bit 2 = C), the high waveform of pair k drives the low pin and the low waveform drives the high pin.
- R7: `en_i` bit order is [0]=AH, [1]=AL, [2]=BH, [3]=BL, [4]=CH, [5]=CL, which is also the bit order of `pwm_o`. A 0 holds that pin low.
- R8: The chopping carrier is a square wave that is high for `chop_div_i`+1 cycles and then low for the same count, starting high after reset. It is ANDed into the high pins when `chop_hi_en_i` is set and into the low pins when `chop_lo_en_i` is set.
- R9: Period, dead time, minimum width and duty values are captured only when the counter turns from down to up. With `dbl_upd_i` low, the waveform is therefore symmetric about the midpoint.
- R10: With `dbl_upd_i` high, the duty values are also captured when the counter turns from up to down, so the second half of a period can differ from the first.
- R11: `trip_ni` low forces all six outputs low with no clock delay. They stay low, even after `trip_ni` returns high, until reset.
- R12: `trip_irq_o` is a single-cycle pulse that appears after the third rising edge following the fall of `trip_ni`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| per_i | input | 16 | Half-period count H |
| dead_i | input | 16 | Dead gap in counts |
| pmin_i | input | 16 | Minimum half-pulse width |
| duty_a_i | input | 16 | Phase A duty |
| duty_b_i | input | 16 | Phase B duty |
| duty_c_i | input | 16 | Phase C duty |
| en_i | input | 6 | Per-pin output enables |
| xover_i | input | 3 | Per-pair crossover |
| chop_div_i | input | 8 | Chopping carrier divider |
| chop_hi_en_i | input | 1 | Chop the high-side pins |
| chop_lo_en_i | input | 1 | Chop the low-side pins |
| dbl_upd_i | input | 1 | Double-update mode |
| trip_ni | input | 1 | Asynchronous active-low trip |
| pwm_o | output | 6 | Gate outputs {CL,CH,BL,BH,AL,AH} |
| sync_o | output | 1 | Period-start pulse |
| trip_irq_o | output | 1 | Trip interrupt pulse |

## Verification
The bench measures on-time per period for duties of zero, mid-range and full scale. An off-by-one threshold, or dead time applied to the wrong side, shows up as a count that is off by two. It changes a duty value in the middle of a period under both update modes. A design that captured duties at the wrong turn point would give the single-update count in double mode, or the reverse. Clamped periods, duties beyond the period, minimum-width suppression, crossover and chopping are mixed in by random stimulus against a cycle model. The trip test checks that outputs fall with no clock delay, stay low after release, and raise exactly one interrupt pulse on the right cycle.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  // One complementary leg before output masking
  typedef struct packed {
    logic hi;
    logic lo;
  } pair_t;

  localparam int unsigned LEG_CNT = 3;

endpackage

// File: rtl/cpwm_tri_cnt.sv
module cpwm_tri_cnt #(
  parameter int CW  = 16,
  parameter int NPH = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [CW-1:0]            per_i,
  input  logic [CW-1:0]            dead_i,
  input  logic [CW-1:0]            pmin_i,
  input  logic [NPH-1:0][CW-1:0]   duty_i,
  input  logic                     dbl_i,
  output logic [CW-1:0]            cnt_o,
  output logic [CW-1:0]            half_o,
  output logic [CW-1:0]            dead_o,
  output logic [CW-1:0]            pmin_o,
  output logic [NPH-1:0][CW-1:0]   duty_o,
  output logic                     start_o
);

  localparam logic [CW-1:0] HALF_MIN = CW'(2);

  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   dn_q, dn_d;
  logic [CW-1:0]          half_q, dead_q, pmin_q;
  logic [NPH-1:0][CW-1:0] duty_q;
  logic [CW-1:0]          half_new;
  logic                   at_top, at_bot;
  logic                   cfg_ld, duty_ld;

  // Turn points of the triangle
  always_comb begin
    at_top   = !dn_q && (cnt_q == half_q - 1'b1);
    at_bot   = dn_q && (cnt_q == '0);
    cfg_ld   = at_bot;
    duty_ld  = at_bot || (at_top && dbl_i);
    half_new = (per_i < HALF_MIN) ? HALF_MIN : per_i;
  end

  // Counter next state: endpoints are held for one extra cycle while turning
  always_comb begin
    cnt_d = cnt_q;
    dn_d  = dn_q;
    if (at_top) begin
      dn_d = 1'b1;
    end else if (at_bot) begin
      dn_d = 1'b0;
    end else if (dn_q) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dn_q  <= dn_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      half_q <= HALF_MIN;
      dead_q <= '0;
      pmin_q <= '0;
    end else if (cfg_ld) begin
      half_q <= half_new;
      dead_q <= dead_i;
      pmin_q <= pmin_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q <= '0;
    end else if (duty_ld) begin
      duty_q <= duty_i;
    end
  end

  assign cnt_o   = cnt_q;
  assign half_o  = half_q;
  assign dead_o  = dead_q;
  assign pmin_o  = pmin_q;
  assign duty_o  = duty_q;
  assign start_o = !dn_q && (cnt_q == '0);

endmodule

// File: rtl/cpwm_leg.sv
module cpwm_leg
  import cpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] half_i,
  input  logic [CW-1:0] duty_i,
  input  logic [CW-1:0] dead_i,
  input  logic [CW-1:0] pmin_i,
  input  logic          xo_i,
  output pair_t         wave_o
);

  localparam int CX = CW + 1;

  logic [CX-1:0] dc, hi_half, lo_half, hi_thr, cnt_x, dead_x, pmin_x;
  logic          hi_ok, lo_ok, hi_on, lo_on;

  always_comb begin
    cnt_x   = {1'b0, cnt_i};
    dead_x  = {1'b0, dead_i};
    pmin_x  = {1'b0, pmin_i};
    dc      = (duty_i > half_i) ? {1'b0, half_i} : {1'b0, duty_i};
    hi_half = dc - dead_x;
    lo_half = {1'b0, half_i} - dc;
    hi_thr  = {1'b0, half_i} - dc + dead_x;
    hi_ok   = (dc > dead_x) && (hi_half >= pmin_x);
    lo_ok   = (lo_half >= pmin_x);
    hi_on   = hi_ok && (cnt_x >= hi_thr);
    lo_on   = lo_ok && (cnt_x < lo_half);
  end

  // Crossover routes each waveform to the partner pin
  always_comb begin
    wave_o.hi = xo_i ? lo_on : hi_on;
    wave_o.lo = xo_i ? hi_on : lo_on;
  end

endmodule

// File: rtl/cpwm_chop.sv
module cpwm_chop #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] div_i,
  output logic          lvl_o
);

  logic [DW-1:0] cnt_q, cnt_d;
  logic          lvl_q, lvl_d;
  logic          wrap;

  always_comb begin
    wrap  = (cnt_q == div_i);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    lvl_d = wrap ? ~lvl_q : lvl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      lvl_q <= lvl_d;
    end
  end

  assign lvl_o = lvl_q;

endmodule

// File: rtl/cpwm_trip.sv
module cpwm_trip (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trip_ni,
  output logic lat_o,
  output logic irq_o
);

  logic meta_q, sync_q;
  logic lat_q, lat_d;
  logic irq_q, irq_d;

  always_comb begin
    lat_d = lat_q || !sync_q;
    irq_d = !sync_q && !lat_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      lat_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      meta_q <= trip_ni;
      sync_q <= meta_q;
      lat_q  <= lat_d;
      irq_q  <= irq_d;
    end
  end

  assign lat_o = lat_q;
  assign irq_o = irq_q;

endmodule

// File: rtl/cpwm_gen.sv
module cpwm_gen
  import cpwm_pkg::*;
#(
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] per_i,
  input  logic [CW-1:0] dead_i,
  input  logic [CW-1:0] pmin_i,
  input  logic [CW-1:0] duty_a_i,
  input  logic [CW-1:0] duty_b_i,
  input  logic [CW-1:0] duty_c_i,
  input  logic [5:0]    en_i,
  input  logic [2:0]    xover_i,
  input  logic [DW-1:0] chop_div_i,
  input  logic          chop_hi_en_i,
  input  logic          chop_lo_en_i,
  input  logic          dbl_upd_i,
  input  logic          trip_ni,
  output logic [5:0]    pwm_o,
  output logic          sync_o,
  output logic          trip_irq_o
);

  localparam int NPH = LEG_CNT;
  localparam int NPIN = 2 * NPH;

  logic [1:0]             rs_q;
  logic                   rst_int_n;
  logic [NPH-1:0][CW-1:0] duty_all, duty_cur;
  logic [CW-1:0]          cnt, half, dead, pmin;
  logic                   start;
  logic                   chop_lvl, hi_gate, lo_gate;
  logic                   trip_lat;
  pair_t [NPH-1:0]        wave;
  logic [NPIN-1:0]        out_d, out_q;
  logic                   sync_q;

  // Reset asserts at once, releases on the second clock edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_int_n = rs_q[1];

  assign duty_all = {duty_c_i, duty_b_i, duty_a_i};

  cpwm_tri_cnt #(.CW(CW), .NPH(NPH)) cnt_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .per_i   (per_i),
    .dead_i  (dead_i),
    .pmin_i  (pmin_i),
    .duty_i  (duty_all),
    .dbl_i   (dbl_upd_i),
    .cnt_o   (cnt),
    .half_o  (half),
    .dead_o  (dead),
    .pmin_o  (pmin),
    .duty_o  (duty_cur),
    .start_o (start)
  );

  cpwm_chop #(.DW(DW)) chop_i (
    .clk_i  (clk_i),
    .rst_ni (rst_int_n),
    .div_i  (chop_div_i),
    .lvl_o  (chop_lvl)
  );

  cpwm_trip trip_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_int_n),
    .trip_ni (trip_ni),
    .lat_o   (trip_lat),
    .irq_o   (trip_irq_o)
  );

  assign hi_gate = chop_hi_en_i ? chop_lvl : 1'b1;
  assign lo_gate = chop_lo_en_i ? chop_lvl : 1'b1;

  for (genvar k = 0; k < NPH; k++) begin : g_leg
    cpwm_leg #(.CW(CW)) leg_i (
      .cnt_i  (cnt),
      .half_i (half),
      .duty_i (duty_cur[k]),
      .dead_i (dead),
      .pmin_i (pmin),
      .xo_i   (xover_i[k]),
      .wave_o (wave[k])
    );
    assign out_d[2*k]   = wave[k].hi && en_i[2*k]   && hi_gate;
    assign out_d[2*k+1] = wave[k].lo && en_i[2*k+1] && lo_gate;
  end

  always_ff @(posedge clk_i or negedge rst_int_n) begin
    if (!rst_int_n) begin
      out_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      out_q  <= out_d;
      sync_q <= start;
    end
  end

  // Trip gates the pins with no clock in the path
  assign pwm_o  = out_q & {NPIN{trip_ni && !trip_lat}};
  assign sync_o = sync_q;

endmodule

// File: rtl/cpwm_gen_chk.sv
module cpwm_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [5:0] en_i,
  input logic       trip_ni,
  input logic [5:0] pwm_o,
  input logic       sync_o,
  input logic       trip_irq_o
);

  logic seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
    end else if (trip_irq_o) begin
      seen_q <= 1'b1;
    end
  end

  // R4
  pair_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pwm_o[0] && pwm_o[1]) && !(pwm_o[2] && pwm_o[3]) && !(pwm_o[4] && pwm_o[5]));

  // R7
  en_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i != 6'h3F) |=> ((pwm_o & ~$past(en_i)) == 6'h00));

  // R11
  trip_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trip_ni |-> (pwm_o == 6'h00));

  // R11
  trip_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q |-> (pwm_o == 6'h00));

  // R12
  irq_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_irq_o |=> !trip_irq_o);

  // R2
  sync_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_o |=> !sync_o);

endmodule

bind cpwm_gen cpwm_gen_chk chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .trip_ni    (trip_ni),
  .pwm_o      (pwm_o),
  .sync_o     (sync_o),
  .trip_irq_o (trip_irq_o)
);

// File: tb/cpwm_gen_tb_top.sv
module cpwm_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] per, dead, pmin, da, db, dc;
  logic [5:0]  en;
  logic [2:0]  xo;
  logic [7:0]  div;
  logic        che_h, che_l, dbl, trip_n;
  logic [5:0]  pwm;
  logic        sync, irq;

  always #10 clk = ~clk;

  cpwm_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .per_i(per), .dead_i(dead), .pmin_i(pmin),
    .duty_a_i(da), .duty_b_i(db), .duty_c_i(dc), .en_i(en), .xover_i(xo),
    .chop_div_i(div), .chop_hi_en_i(che_h), .chop_lo_en_i(che_l),
    .dbl_upd_i(dbl), .trip_ni(trip_n), .pwm_o(pwm), .sync_o(sync),
    .trip_irq_o(irq)
  );

  int    n_chk = 0;
  int    n_err = 0;
  bit    cmp_on = 1'b0;
  string tag = "R3";

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Reference leg from R3..R5
  function automatic logic [1:0] ref_pair(input int c, input int h, input int d,
                                          input int t, input int pm);
    int  e;
    logic hv, lv;
    e  = (d > h) ? h : d;
    hv = (e > t) && ((e - t) >= pm) && (c >= h - e + t);
    lv = ((h - e) >= pm) && (c < h - e);
    return {hv, lv};
  endfunction

  // Cycle model built from the requirements
  int         m_cnt, m_h, m_dt, m_pm;
  int         m_d [3];
  bit         m_dn, m_cl;
  logic [7:0] m_cc;
  logic [1:0] m_rs;
  logic [5:0] exp_out, e_tmp;
  logic       exp_sync;
  logic [1:0] pr;
  logic       hv, lv, tv;

  task automatic model_clear();
    m_cnt = 0; m_dn = 0; m_h = 2; m_dt = 0; m_pm = 0;
    m_d[0] = 0; m_d[1] = 0; m_d[2] = 0;
    m_cc = 8'd0; m_cl = 1'b1; exp_out = 6'd0; exp_sync = 1'b0;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs = 2'b00;
      model_clear();
    end else begin
      if (!m_rs[1]) begin
        model_clear();
      end else begin
        for (int k = 0; k < 3; k++) begin
          pr = ref_pair(m_cnt, m_h, m_d[k], m_dt, m_pm);
          hv = pr[1]; lv = pr[0];
          if (xo[k]) begin tv = hv; hv = lv; lv = tv; end
          e_tmp[2*k]   = hv & en[2*k]   & (che_h ? m_cl : 1'b1);
          e_tmp[2*k+1] = lv & en[2*k+1] & (che_l ? m_cl : 1'b1);
        end
        exp_out  = e_tmp;
        exp_sync = (m_cnt == 0) && !m_dn;
        if (!m_dn) begin
          if (m_cnt == m_h - 1) begin
            m_dn = 1'b1;
            if (dbl) begin m_d[0] = int'(da); m_d[1] = int'(db); m_d[2] = int'(dc); end
          end else m_cnt++;
        end else begin
          if (m_cnt == 0) begin
            m_dn = 1'b0;
            m_h  = (per < 16'd2) ? 2 : int'(per);
            m_dt = int'(dead); m_pm = int'(pmin);
            m_d[0] = int'(da); m_d[1] = int'(db); m_d[2] = int'(dc);
          end else m_cnt--;
        end
        if (m_cc == div) begin m_cc = 8'd0; m_cl = ~m_cl; end
        else m_cc = m_cc + 8'd1;
      end
      m_rs = {m_rs[0], 1'b1};
    end
  end

  // Cycle compare, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      check(pwm == exp_out, tag, "pins", pwm, exp_out);
      check(sync == exp_sync, "R2", "sync", sync, exp_sync);
    end
  end

  task automatic measure(output int c [6], output int len);
    for (int k = 0; k < 6; k++) c[k] = 0;
    len = 0;
    repeat (2) begin
      do @(negedge clk); while (!sync);
    end
    do begin
      for (int k = 0; k < 6; k++) c[k] += int'(pwm[k]);
      len++;
      @(negedge clk);
    end while (!sync);
  endtask

  task automatic base_cfg();
    per = 16'd10; dead = 16'd2; pmin = 16'd0;
    da = 16'd5; db = 16'd0; dc = 16'd10;
    en = 6'h3F; xo = 3'b000; div = 8'd0; che_h = 1'b0; che_l = 1'b0; dbl = 1'b0;
  endtask

  // Mid-period duty change: count AH over the period it lands in
  task automatic upd_test(input bit mode, input int exp_cnt, input string req);
    int c [6];
    int len, acc;
    @(negedge clk); #1;
    per = 16'd10; dead = 16'd0; pmin = 16'd0; da = 16'd4; dbl = mode;
    measure(c, len);
    do @(negedge clk); while (!sync);
    acc = int'(pwm[0]);
    #1 da = 16'd8;
    repeat (19) begin
      @(negedge clk);
      acc += int'(pwm[0]);
    end
    check(acc == exp_cnt, req, "AH cycles in changed period", acc, exp_cnt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int c [6];
    int len, acc, hold;
    void'($urandom(32'd4711));
    rst_n = 1'b0; trip_n = 1'b1;
    base_cfg();
    repeat (3) @(negedge clk);
    check(pwm == 6'd0, "R1", "pins in reset", pwm, 0);
    check(sync == 1'b0, "R1", "sync in reset", sync, 0);
    check(irq == 1'b0, "R1", "irq in reset", irq, 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(pwm == 6'd0, "R1", "pins after release", pwm, 0);
    cmp_on = 1'b1;

    // Directed: zero, mid and full duty
    tag = "R3";
    measure(c, len);
    check(len == 20, "R2", "period length", len, 20);
    check(c[0] == 6, "R3", "AH mid duty", c[0], 6);
    check(c[2] == 0, "R3", "BH zero duty", c[2], 0);
    check(c[4] == 16, "R3", "CH full duty", c[4], 16);
    check(c[1] == 10, "R4", "AL mid duty", c[1], 10);
    check(c[3] == 20, "R4", "BL zero duty", c[3], 20);
    check(c[5] == 0, "R4", "CL full duty", c[5], 0);

    tag = "R5";
    @(negedge clk); #1 pmin = 16'd4;
    measure(c, len);
    check(c[0] == 0, "R5", "AH below min", c[0], 0);
    check(c[1] == 10, "R5", "AL above min", c[1], 10);
    check(c[4] == 16, "R5", "CH above min", c[4], 16);

    tag = "R6";
    @(negedge clk); #1 pmin = 16'd0; xo = 3'b001;
    measure(c, len);
    check(c[0] == 10, "R6", "AH carries low wave", c[0], 10);
    check(c[1] == 6, "R6", "AL carries high wave", c[1], 6);
    check(c[4] == 16, "R6", "CH not crossed", c[4], 16);

    tag = "R7";
    @(negedge clk); #1 xo = 3'b000; en = 6'b111110;
    measure(c, len);
    check(c[0] == 0, "R7", "AH disabled", c[0], 0);
    check(c[1] == 10, "R7", "AL still enabled", c[1], 10);

    tag = "R8";
    @(negedge clk); #1 en = 6'h3F; div = 8'd1; che_h = 1'b1;
    measure(c, len);
    check(c[4] == 8, "R8", "CH chopped", c[4], 8);
    check(c[1] == 10, "R8", "AL not chopped", c[1], 10);

    tag = "R2";
    @(negedge clk); #1 che_h = 1'b0; per = 16'd1;
    measure(c, len);
    check(len == 4, "R2", "clamped period length", len, 4);

    tag = "R9";
    upd_test(1'b0, 8, "R9");
    tag = "R10";
    upd_test(1'b1, 12, "R10");

    // Random mix
    tag = "R3,R4,R5,R6,R7,R8,R9,R10";
    for (int n = 0; n < 400; n++) begin
      @(negedge clk); #1;
      per   = 16'($urandom_range(0, 30));
      dead  = 16'($urandom_range(0, 6));
      pmin  = 16'($urandom_range(0, 6));
      da    = 16'($urandom_range(0, 35));
      db    = 16'($urandom_range(0, 35));
      dc    = 16'($urandom_range(0, 35));
      en    = 6'($urandom);
      xo    = 3'($urandom);
      div   = 8'($urandom_range(0, 5));
      che_h = 1'($urandom);
      che_l = 1'($urandom);
      dbl   = 1'($urandom);
      hold  = $urandom_range(1, 15);
      repeat (hold) @(negedge clk);
    end

    // Trip
    tag = "R11";
    @(negedge clk); #1 base_cfg(); dead = 16'd0;
    measure(c, len);
    check(pwm[3] == 1'b1, "R11", "BL on before trip", pwm[3], 1);
    #1 cmp_on = 1'b0; trip_n = 1'b0;
    #1 check(pwm == 6'd0, "R11", "pins on trip", pwm, 0);
    acc = 0;
    for (int n = 1; n <= 10; n++) begin
      @(negedge clk);
      if (n == 3) check(irq == 1'b1, "R12", "irq on third edge", irq, 1);
      else if (irq) check(1'b0, "R12", "irq extra cycle", n, 3);
      acc += int'(irq);
    end
    check(acc == 1, "R12", "irq pulse count", acc, 1);
    #1 trip_n = 1'b1;
    acc = 0;
    repeat (40) begin
      @(negedge clk);
      acc += $countones(pwm);
    end
    check(acc == 0, "R11", "pins held after release", acc, 0);
    #1 rst_n = 1'b0;
    @(negedge clk); #1 rst_n = 1'b1;
    cmp_on = 1'b1; tag = "R11";
    measure(c, len);
    check(c[3] == 20, "R11", "BL back after reset", c[3], 20);

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule